// File: doc/BRIEF.md
# Shifted-Operand Adder with Flags

This block is the integer add stage of a load/store processor datapath. It forms a 64-bit sum from a first register operand and a second operand. The second operand comes from one of two places: a 12-bit unsigned constant, which can be moved up by 12 bit positions, or a second register value that passes through a barrel shifter. The shifter can move left, move right with zero fill, or move right with sign fill, by any amount from 0 to 63.

The sum appears on the result output in the same cycle, with no register in its path. A four-bit condition flag register records negative, zero, carry and signed overflow for the sum. It is written on the next rising clock edge only when the operation asks for its flags to be set. When it does not, the flags are held. The form that sets flags therefore has the same latency as the plain form.

Instruction decode, the register file and memory are outside this block. The block only sees the decoded operand and control fields.

Top module: `sadd_unit`

## Requirements
- R1: `result` equals `opa` plus the selected second operand, modulo 2^64, combinationally in the same cycle as the inputs.
- R2: When `use_imm`=1 the second operand is `imm` zero-extended to 64 bits. It is shifted left by 12 when `imm_hi`=1. In this mode `opb`, `sh_kind` and `sh_amt` have no effect on `result`.
- R3: When `use_imm`=0 and `sh_kind` is 2'b00 (or the reserved code 2'b11), the second operand is `opb` shifted left by `sh_amt`, with zeros shifted in.
- R4: When `use_imm`=0 and `sh_kind`=2'b01, the second operand is `opb` shifted right by `sh_amt`, with zeros shifted in.
- R5: When `use_imm`=0 and `sh_kind`=2'b10, the second operand is `opb` shifted right by `sh_amt`, with copies of `opb[63]` shifted in.
- R6: The flags are packed as `flags` = {N, Z, C, V}, with N at bit 3 and V at bit 0. When `set_flags`=1 at a rising edge, N takes `result[63]` and Z becomes 1 exactly when `result` is zero.
- R7: When `set_flags`=1 at a rising edge, C takes the unsigned carry out of bit 63 of the add.
- R8: When `set_flags`=1 at a rising edge, V becomes 1 exactly when `opa` and the post-shift second operand have equal sign bits and `result[63]` differs from them.
- R9: When `set_flags`=0 at a rising edge, `flags` keeps its previous value.
- R10: A synchronous active-high `rst` clears `flags` to 4'b0000 and takes priority over `set_flags`.
- R11: A register-mode shift amount of 0 passes `opb` unchanged for every shift kind. An amount of 63 moves bit 63 to bit 0 (right shifts) or bit 0 to bit 63 (left shift).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opa | input | 64 | First register operand |
| opb | input | 64 | Second register operand (register mode) |
| imm | input | 12 | Unsigned immediate (immediate mode) |
| use_imm | input | 1 | 1 selects the immediate, 0 selects shifted `opb` |
| imm_hi | input | 1 | 1 moves the immediate up by 12 bits |
| sh_kind | input | 2 | 00 left, 01 right zero fill, 10 right sign fill, 11 as 00 |
| sh_amt | input | 6 | Shift amount 0..63 for `opb` |
| set_flags | input | 1 | 1 writes the flags at the next rising edge |
| result | output | 64 | Combinational sum |
| flags | output | 4 | Registered {N, Z, C, V} |

## Verification
The combinational sum and the flag register write can act in the same cycle. The flag write then depends on the sum being stable before the edge. A reset also competes with a flag write. The bench raises `set_flags` and `rst` together, and checks that the flags read zero after the edge rather than the values the sum would give. It also drives operand pairs that set carry, overflow and zero at once, such as two values with only bit 63 set. The bench reads `result` before the edge and `flags` half a cycle after it, and compares both with a 65-bit reference sum that it computes itself.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'b00,
    SK_RIGHT = 2'b01,
    SK_ARITH = 2'b10,
    SK_RSVD  = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cond_flags_t;

  // Sum with the carry out in the top bit.
  function automatic logic [64:0] wide_add(input logic [63:0] x, input logic [63:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // Signed overflow: same input signs, different result sign.
  function automatic logic sign_overflow(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  function automatic cond_flags_t pack_flags(input logic [63:0] s, input logic co, input logic ov);
    cond_flags_t f;
    f.neg   = s[63];
    f.zero  = (s == '0);
    f.carry = co;
    f.ovf   = ov;
    return f;
  endfunction

endpackage

// File: rtl/sadd_imm_prep.sv
module sadd_imm_prep #(
  parameter int W   = 64,
  parameter int IW  = 12,
  parameter int HSH = 12
) (
  input  logic [IW-1:0] imm,
  input  logic          hi,
  output logic [W-1:0]  val
);
  localparam int PADW = W - IW;
  logic [W-1:0] ext;

  assign ext = {{PADW{1'b0}}, imm};
  assign val = hi ? (ext << HSH) : ext;
endmodule

// File: rtl/sadd_shifter.sv
module sadd_shifter
  import sadd_pkg::*;
#(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  shift_kind_e   kind,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [SW:0][W-1:0] stg;
  logic fill;

  assign fill   = (kind == SK_ARITH) & din[W-1];
  assign stg[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    always_comb begin
      if (!amt[s]) begin
        stg[s+1] = stg[s];
      end else begin
        case (kind)
          SK_RIGHT: stg[s+1] = {{D{1'b0}}, stg[s][W-1:D]};
          SK_ARITH: stg[s+1] = {{D{fill}}, stg[s][W-1:D]};
          default:  stg[s+1] = {stg[s][W-1-D:0], {D{1'b0}}};
        endcase
      end
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/sadd_adder.sv
module sadd_adder
  import sadd_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] full;

  assign full = wide_add(a, b);
  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign ovf  = sign_overflow(a[W-1], b[W-1], full[W-1]);
endmodule

// File: rtl/sadd_flagreg.sv
module sadd_flagreg
  import sadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  cond_flags_t nxt,
  output cond_flags_t cur
);
  always_ff @(posedge clk) begin
    if (rst)     cur <= '0;
    else if (wr) cur <= nxt;
  end
endmodule

// File: rtl/sadd_unit.sv
module sadd_unit
  import sadd_pkg::*;
#(
  parameter int W  = 64,
  parameter int IW = 12,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  input  logic          imm_hi,
  input  logic [1:0]    sh_kind,
  input  logic [SW-1:0] sh_amt,
  input  logic          set_flags,
  output logic [W-1:0]  result,
  output logic [3:0]    flags
);
  logic [W-1:0] imm_val;
  logic [W-1:0] reg_val;
  logic [W-1:0] operand2;
  logic         add_cout;
  logic         add_ovf;
  cond_flags_t  flag_nxt;
  cond_flags_t  flag_cur;

  sadd_imm_prep #(.W(W), .IW(IW), .HSH(IW)) u_imm (
    .imm (imm),
    .hi  (imm_hi),
    .val (imm_val)
  );

  sadd_shifter #(.W(W), .SW(SW)) u_shift (
    .din  (opb),
    .kind (shift_kind_e'(sh_kind)),
    .amt  (sh_amt),
    .dout (reg_val)
  );

  assign operand2 = use_imm ? imm_val : reg_val;

  sadd_adder #(.W(W)) u_add (
    .a    (opa),
    .b    (operand2),
    .sum  (result),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  assign flag_nxt = pack_flags(result, add_cout, add_ovf);

  sadd_flagreg u_flags (
    .clk (clk),
    .rst (rst),
    .wr  (set_flags),
    .nxt (flag_nxt),
    .cur (flag_cur)
  );

  assign flags = flag_cur;
endmodule

// File: rtl/sadd_unit_chk.sv
module sadd_unit_chk #(
  parameter int W  = 64,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          set_flags,
  input logic          use_imm,
  input logic [SW-1:0] sh_amt,
  input logic [W-1:0]  opb,
  input logic [W-1:0]  operand2,
  input logic [W-1:0]  result,
  input logic          add_cout,
  input logic          add_ovf,
  input logic [3:0]    flags
);
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> $stable(flags));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (flags == 4'b0000));

  assert_neg_zero_R6: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flags[3] == $past(result[W-1])) && (flags[2] == ($past(result) == '0)));

  assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flags[1] == $past(add_cout)));

  assert_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flags[0] == $past(add_ovf)));

  assert_zero_shift_R11: assert property (@(posedge clk) disable iff (rst)
    (!use_imm && (sh_amt == '0)) |-> (operand2 == opb));
endmodule

bind sadd_unit sadd_unit_chk #(.W(W), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .set_flags (set_flags),
  .use_imm   (use_imm),
  .sh_amt    (sh_amt),
  .opb       (opb),
  .operand2  (operand2),
  .result    (result),
  .add_cout  (add_cout),
  .add_ovf   (add_ovf),
  .flags     (flags)
);

// File: tb/sadd_unit_test.sv
`timescale 1ns/1ps
module sadd_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] opa, opb;
  logic [11:0] imm;
  logic        use_imm, imm_hi, set_flags;
  logic [1:0]  sh_kind;
  logic [5:0]  sh_amt;
  logic [63:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sadd_unit uut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .imm(imm),
    .use_imm(use_imm), .imm_hi(imm_hi), .sh_kind(sh_kind), .sh_amt(sh_amt),
    .set_flags(set_flags), .result(result), .flags(flags)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [11:0] im;
    logic        ui;
    logic        ih;
    logic [1:0]  k;
    logic [5:0]  n;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{64'h0, 64'h0, 12'h0, 1'b0, 1'b0, 2'd0, 6'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 1'b0, 1'b0, 2'd0, 6'd0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 1'b0, 1'b0, 2'd0, 6'd0},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 12'h0, 1'b0, 1'b0, 2'd0, 6'd0},
    '{64'd100, 64'hDEAD, 12'd20, 1'b1, 1'b0, 2'd2, 6'd9},
    '{64'h1234_5678, 64'h0, 12'hFFF, 1'b1, 1'b1, 2'd0, 6'd0},
    '{64'h1000, 64'd5, 12'h0, 1'b0, 1'b0, 2'd0, 6'd3},
    '{64'h0, 64'h1, 12'h0, 1'b0, 1'b0, 2'd0, 6'd63},
    '{64'h0, 64'h8000_0000_0000_0000, 12'h0, 1'b0, 1'b0, 2'd1, 6'd63},
    '{64'h1, 64'h8000_0000_0000_0000, 12'h0, 1'b0, 1'b0, 2'd2, 6'd63},
    '{64'h5, 64'hF000_0000_0000_0000, 12'h0, 1'b0, 1'b0, 2'd2, 6'd4},
    '{64'h3, 64'h0123_4567_89AB_CDEF, 12'h0, 1'b0, 1'b0, 2'd3, 6'd4},
    '{64'hA5A5_0000_FFFF_1234, 64'hC3C3_9999_0000_8888, 12'h0, 1'b0, 1'b0, 2'd1, 6'd17},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h001, 1'b1, 1'b0, 2'd0, 6'd0}
  };

  function automatic logic [63:0] ref_op2(input vec_t v);
    logic [63:0] iv;
    iv = {52'd0, v.im};
    if (v.ui) return v.ih ? {iv[51:0], 12'd0} : iv;
    case (v.k)
      2'd1:    return v.b >> v.n;
      2'd2:    return $unsigned($signed(v.b) >>> v.n);
      default: return v.b << v.n;
    endcase
  endfunction

  function automatic logic [64:0] ref_sum(input vec_t v);
    logic [64:0] a65, b65;
    a65 = {1'b0, v.a};
    b65 = {1'b0, ref_op2(v)};
    return a65 + b65;
  endfunction

  function automatic logic [3:0] ref_flags(input vec_t v);
    logic [64:0] s;
    logic [63:0] b2;
    logic nf, zf, cf, vf;
    s  = ref_sum(v);
    b2 = ref_op2(v);
    nf = s[63];
    zf = (s[63:0] == 64'd0);
    cf = s[64];
    vf = (v.a[63] == b2[63]) && (s[63] != v.a[63]);
    return {nf, zf, cf, vf};
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic sf);
    opa = v.a; opb = v.b; imm = v.im; use_imm = v.ui; imm_hi = v.ih;
    sh_kind = v.k; sh_amt = v.n; set_flags = sf;
  endtask

  // One operation: result checked before the edge, flags after it.
  task automatic run_vec(input vec_t v, input string req);
    @(negedge clk);
    drive(v, 1'b1);
    #1;
    chk64({req, " result (R1)"}, result, ref_sum(v)[63:0]);
    @(negedge clk);
    chk4({req, " flags (R6 R7 R8)"}, flags, ref_flags(v));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    vec_t v, w;
    logic [63:0] seed;
    logic [3:0]  held;
    rst = 1'b1;
    drive('0, 1'b1);
    repeat (3) @(negedge clk);
    chk4("R10 reset clears flags", flags, 4'b0000);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      case (i)
        4, 5, 13: run_vec(TBL[i], "R2 imm");
        7:        run_vec(TBL[i], "R3 R11 lsl63");
        8:        run_vec(TBL[i], "R4 R11 lsr63");
        9:        run_vec(TBL[i], "R5 R11 asr63");
        10:       run_vec(TBL[i], "R5 asr");
        11:       run_vec(TBL[i], "R3 rsvd kind");
        12:       run_vec(TBL[i], "R4 lsr");
        default:  run_vec(TBL[i], "R1 R6 R7 R8 corner");
      endcase
    end

    // Zero shift for every kind (R11)
    for (int k = 0; k < 4; k++) begin
      v = '{64'h1111_2222_3333_4444, 64'h8765_4321_0FED_CBA9, 12'h0, 1'b0, 1'b0, 2'(k), 6'd0};
      run_vec(v, "R11 zero shift");
    end

    // R2: register-side inputs ignored in immediate mode
    v = '{64'h4000, 64'h0, 12'h123, 1'b1, 1'b1, 2'd0, 6'd0};
    w = v; w.b = 64'hFFFF_0000_FFFF_0000; w.k = 2'd2; w.n = 6'd31;
    @(negedge clk); drive(v, 1'b0); #1;
    chk64("R2 imm baseline", result, 64'h0012_7000);
    drive(w, 1'b0); #1;
    chk64("R2 opb/shift ignored", result, 64'h0012_7000);

    // R9: flags hold when set_flags is low
    run_vec(TBL[3], "R9 setup");
    held = ref_flags(TBL[3]);
    @(negedge clk); drive(TBL[6], 1'b0);
    @(negedge clk);
    chk4("R9 flags held", flags, held);
    chk64("R9 result still produced", result, ref_sum(TBL[6])[63:0]);

    // R10: reset wins over set_flags in the same cycle
    @(negedge clk); drive(TBL[2], 1'b1); rst = 1'b1;
    @(negedge clk);
    chk4("R10 reset priority", flags, 4'b0000);
    rst = 1'b0;

    // Pseudo-random sweep
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 300; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      v.a = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      v.b = seed;
      v.im = seed[11:0]; v.ui = seed[12]; v.ih = seed[13];
      v.k = seed[15:14]; v.n = seed[21:16];
      run_vec(v, "R1-sweep R3 R4 R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule